// File: doc/BRIEF.md
# Frequency Hop Profile Sequencer

This block picks which of eight stored fast-lock tuning profiles a transceiver uses, and drives the 3-bit profile index straight onto its control pins. In automatic mode it steps through the profiles in order and wraps from the last one back to the first. It keeps each profile for a dwell that is measured in data samples, counted on a sample-valid strobe. A dwell is a fixed settling stretch of 20 samples followed by a programmable count N.

A receive-capture enable is high only in the settled tail of each dwell, so samples taken while the synthesizer relocks are thrown away. A force bit holds the capture enable high. A manual override pins the index to a value set by software.

Control comes from a small register bank. It has a single-cycle write strobe, a 12-bit address and 32-bit data, and a combinational read port. A one-clock change pulse marks every change of the output index.

Top module: `hop_sequencer`

## Requirements
- R1: While reset (synchronous, active low) is applied, and once it is released, the index is 0, capture and the change pulse are low, and every register reads 0.
- R2: With hopping enabled and the override clear, the index advances by one at the end of each dwell, in the order 0,1,…,7, and then wraps to 0.
- R3: A dwell lasts exactly 20+N sample-valid cycles, where N is the 32-bit dwell register. Cycles with sample-valid low do not count.
- R4: With hopping disabled, the index holds its last value and the dwell count is cleared. Enabling hopping again starts a complete new dwell.
- R5: While the override bit is set, the index equals the 3-bit manual register, and the dwell count is held at zero. Clearing the bit restores the sequencer's index and starts a fresh dwell.
- R6: In automatic mode, capture is high for the last N samples of each dwell and low for its first 20. With N=0 capture never rises.
- R7: While the force bit is set, capture is high in every mode.
- R8: The register offsets are: dwell count at 0x100 (bits 31:0), hopping enable at 0x104 (bit 0), force at 0x108 (bit 0), manual index at 0x120 (bits 2:0), and override enable at 0x124 (bit 0). A write is visible on the following clock. A read returns the stored field with its other bits zero. Unmapped offsets read 0, and writes to them change nothing.
- R9: The change pulse is high for exactly the cycles in which the index differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 12 | Register byte offset, used for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sample_valid | input | 1 | One data sample present this cycle |
| profile_idx | output | 3 | Selected profile index, drives the control pins |
| capture_en | output | 1 | Receive-capture enable |
| profile_change | output | 1 | High for one cycle when `profile_idx` changes |

## Verification
The bench uses the default parameters: eight profiles and a 20-sample settling stretch. It programs small dwell values (N of 0 and 2), so that a full 0-to-7 rotation and its wrap fit in a few hundred clocks. The same small dwells bring several other cases within reach: a dwell with no capture window at all, dwells stretched by gaps in sample-valid, and a re-enable in the middle of a dwell. The dwell register is also written with a value that uses all 32 bits and read back, which checks the full field width without waiting through such a dwell.

// File: rtl/hop_pkg.sv
// hop_pkg: widths, register offsets and the configuration record shared by
// the hop sequencer modules. Offsets are byte addresses on a 12-bit bus.
package hop_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_DWELL  = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_HOP    = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_FORCE  = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_MIDX   = 12'h120;
    localparam logic [ADDR_W-1:0] OFS_MEN    = 12'h124;

    typedef struct packed {
        logic [DATA_W-1:0] dwell;
        logic              hop_en;
        logic              force_en;
        logic [IDX_W-1:0]  man_idx;
        logic              man_en;
    } hop_cfg_t;
endpackage

// File: rtl/hop_regs.sv
// hop_regs: control register bank. Writes land on the clock edge that
// samples reg_wr. Reads are combinational and return zero-extended fields.
// Assumes a full 12-bit address decode; unmapped offsets read as zero.
module hop_regs
    import hop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output hop_cfg_t          cfg
);
    // Store the written field of the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr) begin
            case (addr)
                OFS_DWELL: cfg.dwell    <= wdata;
                OFS_HOP:   cfg.hop_en   <= wdata[0];
                OFS_FORCE: cfg.force_en <= wdata[0];
                OFS_MIDX:  cfg.man_idx  <= wdata[IDX_W-1:0];
                OFS_MEN:   cfg.man_en   <= wdata[0];
                default:   ;
            endcase
        end
    end

    // Return the addressed field, zero-extended.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_DWELL: rdata = cfg.dwell;
            OFS_HOP:   rdata[0] = cfg.hop_en;
            OFS_FORCE: rdata[0] = cfg.force_en;
            OFS_MIDX:  rdata[IDX_W-1:0] = cfg.man_idx;
            OFS_MEN:   rdata[0] = cfg.man_en;
            default:   rdata = '0;
        endcase
    end

    AST_DWELL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_DWELL) |=> (cfg.dwell == $past(wdata))); // R8
endmodule

// File: rtl/hop_seq.sv
// hop_seq: dwell counter and profile rotation. While active, each
// sample_valid cycle counts. When a dwell of SETTLE+dwell samples ends, the
// index steps by one (wrapping) and the count restarts. While inactive, the
// count is held at zero and the index is frozen. Assumes SETTLE >= 1.
module hop_seq
    import hop_pkg::*;
#(
    parameter int SETTLE = 20,
    localparam int CNT_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] dwell,
    output logic [IDX_W-1:0]  seq_idx,
    output logic              settled
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last    = CNT_W'(SETTLE - 1) + CNT_W'(dwell);
    assign settled = (cnt >= CNT_W'(SETTLE));

    // Count samples and rotate the index when a dwell ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            seq_idx <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (sample_valid) begin
            if (cnt >= last) begin
                cnt     <= '0;
                seq_idx <= seq_idx + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idx != $past(seq_idx)) |-> (seq_idx == IDX_W'($past(seq_idx) + 1'b1))); // R2
    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(seq_idx)); // R4
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !settled); // R4
endmodule

// File: rtl/hop_sequencer.sv
// hop_sequencer: top level. It joins the register bank and the sequencer,
// applies the manual override to the index, gates capture to the settled
// part of a dwell (or forces it), and pulses when the index changes.
module hop_sequencer
    import hop_pkg::*;
#(
    parameter int SETTLE = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sample_valid,
    output logic [IDX_W-1:0]  profile_idx,
    output logic              capture_en,
    output logic              profile_change
);
    hop_cfg_t         cfg;
    logic [IDX_W-1:0] seq_idx;
    logic [IDX_W-1:0] idx_q;
    logic             settled;
    logic             active;

    hop_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    assign active = cfg.hop_en & ~cfg.man_en;

    hop_seq #(.SETTLE(SETTLE)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .sample_valid (sample_valid),
        .dwell        (cfg.dwell),
        .seq_idx      (seq_idx),
        .settled      (settled)
    );

    assign profile_idx    = cfg.man_en ? cfg.man_idx : seq_idx;
    assign capture_en     = cfg.force_en | (active & settled);
    assign profile_change = (profile_idx != idx_q);

    // Remember last cycle's index for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= profile_idx;
    end

    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (profile_change && !cfg.force_en) |-> !capture_en); // R6
    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.man_en && $past(cfg.man_en) && $stable(cfg.man_idx)) |-> !profile_change); // R5
endmodule

// File: tb/sim_hop_sequencer.sv
// Bench for hop_sequencer: a register vector table walked by a loop, then
// directed runs checked against a cycle model written from the requirements.
module sim_hop_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sample_valid = 1'b0;
    logic [2:0]  profile_idx;
    logic        capture_en;
    logic        profile_change;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    logic [2:0]  m_seq = '0, m_manidx = '0, m_prev = '0;
    logic [32:0] m_cnt = '0;
    logic [31:0] m_n = '0;
    logic        m_hop = 0, m_force = 0, m_man = 0;

    always #4 clk = ~clk;

    hop_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sample_valid(sample_valid),
        .profile_idx(profile_idx), .capture_en(capture_en), .profile_change(profile_change)
    );

    // {addr, write data, expected read-back}
    localparam int NV = 8;
    localparam logic [75:0] VEC [NV] = '{
        {12'h100, 32'hDEADBEEF, 32'hDEADBEEF},
        {12'h100, 32'h00000002, 32'h00000002},
        {12'h104, 32'hFFFFFFFE, 32'h00000000},
        {12'h108, 32'h00000006, 32'h00000000},
        {12'h120, 32'hFFFFFFFD, 32'h00000005},
        {12'h124, 32'h00000002, 32'h00000000},
        {12'h10C, 32'hFFFFFFFF, 32'h00000000},
        {12'h120, 32'h00000000, 32'h00000000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock: drive, update the model at the edge, check at the negedge.
    task automatic cycle(input logic sv, input logic wr, input logic [11:0] a,
                         input logic [31:0] d, input string tag);
        logic [2:0] e_idx;
        logic       e_cap;
        sample_valid = sv; reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        if (!(m_hop && !m_man)) m_cnt = '0;
        else if (sv) begin
            if (m_cnt >= {1'b0, m_n} + 33'd19) begin m_cnt = '0; m_seq = m_seq + 3'd1; end
            else m_cnt = m_cnt + 33'd1;
        end
        if (wr) begin
            case (a)
                12'h100: m_n = d;
                12'h104: m_hop = d[0];
                12'h108: m_force = d[0];
                12'h120: m_manidx = d[2:0];
                12'h124: m_man = d[0];
                default: ;
            endcase
        end
        @(negedge clk);
        reg_wr = 1'b0; sample_valid = 1'b0;
        e_idx = m_man ? m_manidx : m_seq;
        e_cap = m_force || (m_hop && !m_man && m_cnt >= 33'd20);
        check({tag, " profile_idx"}, 32'(profile_idx), 32'(e_idx));
        check(m_force ? "R7 capture_en" : "R6 capture_en", 32'(capture_en), 32'(e_cap));
        check("R9 profile_change", 32'(profile_change), 32'(e_idx != m_prev));
        m_prev = e_idx;
    endtask

    task automatic run(input int n, input bit alt, input string tag);
        for (int i = 0; i < n; i++) cycle(alt ? logic'(i % 2) : 1'b1, 1'b0, 12'h0, 32'h0, tag);
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d, input string tag);
        cycle(1'b0, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under reset
        check("R1 idx", 32'(profile_idx), 0);
        check("R1 capture", 32'(capture_en), 0);
        check("R1 change", 32'(profile_change), 0);
        rd(12'h100, 0, "R1 dwell"); rd(12'h104, 0, "R1 hop");
        rd(12'h108, 0, "R1 force"); rd(12'h120, 0, "R1 midx"); rd(12'h124, 0, "R1 men");
        rst_n = 1'b1;
        cycle(1'b1, 1'b0, 12'h0, 32'h0, "R1");

        // R8: register table
        for (int v = 0; v < NV; v++) begin
            wreg(VEC[v][75:64], VEC[v][63:32], "R8");
            rd(VEC[v][75:64], VEC[v][31:0], "R8 readback");
        end
        rd(12'h100, 32'h2, "R8 dwell after unmapped write");

        // R2/R3: full rotation with N=2 and continuous samples
        wreg(12'h104, 32'h1, "R4");
        run(8 * 22 + 10, 1'b0, "R2");
        // R3: gaps in sample-valid stretch the dwell
        run(70, 1'b1, "R3");
        // R4: disable mid dwell, then re-enable
        run(5, 1'b0, "R4");
        wreg(12'h104, 32'h0, "R4");
        run(12, 1'b0, "R4");
        wreg(12'h104, 32'h1, "R4");
        run(30, 1'b0, "R4");
        // R5: manual override
        wreg(12'h120, 32'h6, "R5");
        wreg(12'h124, 32'h1, "R5");
        run(10, 1'b0, "R5");
        wreg(12'h120, 32'h2, "R5");
        run(3, 1'b0, "R5");
        wreg(12'h124, 32'h0, "R5");
        run(25, 1'b0, "R5");
        // R7: forced capture, in automatic mode and with hopping off
        wreg(12'h108, 32'h1, "R7");
        run(25, 1'b0, "R7");
        wreg(12'h104, 32'h0, "R7");
        run(4, 1'b0, "R7");
        wreg(12'h108, 32'h0, "R7");
        wreg(12'h104, 32'h1, "R7");
        // R6: N=0 gives no capture window
        wreg(12'h100, 32'h0, "R6");
        run(50, 1'b0, "R6");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule